// File: doc/BRIEF.md
# Dual-Bank Gamut Remap Matrix

This block applies a 3x4 colour matrix to a stream of RGB pixels. Every output channel is a weighted sum of the three input channels plus a constant offset. The result is rounded to the nearest integer and clamped to the unsigned pixel range. Two full coefficient banks, A and B, sit in host-written registers. A pending mode chooses pass-through, bank A or bank B.

The pending mode takes effect only when the frame-start strobe arrives. The mode actually in force is driven out as `cur_mode`. Host software can therefore fill the idle bank during a frame and swap to it at the next frame boundary, so no frame mixes two matrices. Converting floating-point matrices to the fixed-point register format is done by the host.

Pixels enter with a valid flag and leave three cycles later with the flag carried alongside them.

Top module: `cmx_gamut_matrix`

## Requirements
- R1: After reset, `out_valid` is 0, `out_rgb` is 0, `cur_mode` is 0 (pass-through), and every coefficient of both banks is 0.
- R2: A host write with `cfg_addr` k in 0..5 loads bank A and a write with `cfg_addr` 8+k loads bank B. Each such register holds two coefficients: bits [15:0] hold coefficient 2k and bits [31:16] hold coefficient 2k+1. Coefficient index 4*row+col covers rows 0..2 (outputs red, green, blue) and columns 0..3 (red weight, green weight, blue weight, offset).
- R3: A write to `cfg_addr` 15 sets the pending mode from `cfg_wdata[1:0]`: 0 is pass-through, 1 is bank A, 2 is bank B, and 3 is stored as pass-through. `cur_mode` never shows 3.
- R4: On a clock edge where `frame_start` is high, `cur_mode` takes the pending mode; at all other edges it is unchanged. A pixel is processed with the mode and coefficients in force on the edge that accepts it, so a pixel accepted together with the strobe still uses the old mode.
- R5: In pass-through mode the output pixel equals the input pixel, whatever the banks hold.
- R6: In bank mode, out_row = W0*R + W1*G + W2*B + OFS. The weights are signed 16-bit two's complement with 13 fractional bits. The offset is a signed 16-bit integer in pixel units.
- R7: The fractional result is rounded to nearest, with halves rounded up toward positive infinity (add 0.5, then floor).
- R8: Results below 0 give 0 and results above 1023 give 1023.
- R9: Every pixel accepted with `in_valid` appears exactly three cycles later with `out_valid` high. Back-to-back pixels come out back to back.
- R10: Writes to the bank that is not in force do not change any output until a frame-start swap selects that bank.
- R11: While `out_valid` is low, `out_rgb` keeps its last value.
- R12: Writes to the unused addresses 6, 7 and 14 change neither bank nor the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Host register write strobe |
| cfg_addr | input | 4 | Host register address |
| cfg_wdata | input | 32 | Host write data |
| frame_start | input | 1 | Frame boundary strobe; applies the pending mode |
| in_valid | input | 1 | Input pixel valid |
| in_rgb | input | 30 | Input pixel: R in [29:20], G in [19:10], B in [9:0] |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 30 | Output pixel, same channel layout as the input |
| cur_mode | output | 2 | Mode currently applied to pixels |

## Verification
Four things are watched on every cycle: that `cur_mode` moves only on a frame-start edge and then to the pending value, that it is never 3, that each accepted pixel leaves after exactly three cycles, and that pass-through pixels come out bit-exact with the held output otherwise stable. The arithmetic itself needs the bench's reference model. That covers coefficient packing, signed weights, offsets, half-up rounding and both clamp limits. Shadow-bank isolation, strobe/pixel coincidence and ignored addresses likewise only show up under the bench's scenarios.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  localparam int NROW    = 3;
  localparam int NCOL    = 4;
  localparam int NCOEF   = NROW * NCOL;
  localparam int NREG    = NCOEF / 2;
  localparam int ADDR_W  = 4;
  localparam logic [ADDR_W-1:0] ADDR_B_BASE = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = 4'd15;

  typedef enum logic [1:0] {
    MODE_BYP  = 2'd0,
    MODE_SETA = 2'd1,
    MODE_SETB = 2'd2
  } mode_e;
endpackage

// File: rtl/cmx_mode_ctl.sv
module cmx_mode_ctl
  import cmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [1:0]        cfg_wmode,
  input  logic              frame_start,
  output logic [1:0]        cur_mode
);
  mode_e pend_q, pend_d;
  mode_e cur_q, cur_d;
  logic  pend_en;

  assign pend_en = cfg_we && (cfg_addr == ADDR_MODE);

  always_comb begin
    pend_d = pend_q;
    if (pend_en) begin
      case (cfg_wmode)
        2'd1:    pend_d = MODE_SETA;
        2'd2:    pend_d = MODE_SETB;
        default: pend_d = MODE_BYP;
      endcase
    end
    cur_d = frame_start ? pend_q : cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= MODE_BYP;
      cur_q  <= MODE_BYP;
    end else begin
      if (pend_en)     pend_q <= pend_d;
      if (frame_start) cur_q  <= cur_d;
    end
  end

  assign cur_mode = cur_q;

  // R4: swap takes the pending value
  a_r4_swap_takes_pending: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (cur_q == $past(pend_q)));
  // R4: no strobe, no change
  a_r4_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cur_q));
  // R3: value 3 never in force
  a_r3_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cur_mode != 2'd3);
endmodule

// File: rtl/cmx_coef_bank.sv
module cmx_coef_bank
  import cmx_pkg::*;
#(
  parameter int COEF_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [2*COEF_W-1:0]     cfg_wdata,
  input  logic [1:0]              cur_mode,
  output logic [NCOEF*COEF_W-1:0] sel_coef
);
  localparam int DW = 2 * COEF_W;

  logic [DW-1:0] bank_a_q [NREG];
  logic [DW-1:0] bank_b_q [NREG];
  logic [DW-1:0] bank_a_d [NREG];
  logic [DW-1:0] bank_b_d [NREG];
  logic          hit_a, hit_b;
  logic [ADDR_W-1:0] b_off;

  assign b_off = cfg_addr - ADDR_B_BASE;
  assign hit_a = cfg_we && (cfg_addr < ADDR_W'(NREG));
  assign hit_b = cfg_we && (cfg_addr >= ADDR_B_BASE) && (b_off < ADDR_W'(NREG));

  always_comb begin
    bank_a_d = bank_a_q;
    bank_b_d = bank_b_q;
    for (int k = 0; k < NREG; k++) begin
      if (hit_a && (cfg_addr == ADDR_W'(k))) bank_a_d[k] = cfg_wdata;
      if (hit_b && (b_off == ADDR_W'(k)))    bank_b_d[k] = cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) begin
        bank_a_q[k] <= '0;
        bank_b_q[k] <= '0;
      end
    end else begin
      if (hit_a) bank_a_q <= bank_a_d;
      if (hit_b) bank_b_q <= bank_b_d;
    end
  end

  // Coefficient i lives in register i/2, half i%2 (low half first).
  for (genvar i = 0; i < NCOEF; i++) begin : g_sel
    localparam int RI = i / 2;
    localparam int HI = i % 2;
    assign sel_coef[i*COEF_W +: COEF_W] = (cur_mode == MODE_SETB)
      ? bank_b_q[RI][HI*COEF_W +: COEF_W]
      : bank_a_q[RI][HI*COEF_W +: COEF_W];
  end
endmodule

// File: rtl/cmx_row.sv
module cmx_row
  import cmx_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 13,
  parameter int CH     = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s1_en,
  input  logic                     s2_en,
  input  logic                     s3_en,
  input  logic                     byp_in,
  input  logic [NROW*PIX_W-1:0]    pix_in,
  input  logic [NCOL*COEF_W-1:0]   coef_in,
  output logic [PIX_W-1:0]         pix_out
);
  localparam int PROD_W = COEF_W + PIX_W + 1;
  localparam int ACC_W  = PROD_W + 3;
  localparam logic signed [ACC_W-1:0] RND = ACC_W'(1) <<< (FRAC_W - 1);

  // stage 1: products
  logic signed [PROD_W-1:0] prod_d [NROW];
  logic signed [PROD_W-1:0] prod_q [NROW];
  logic        [COEF_W-1:0] ofs_q;
  logic                     byp1_q;
  logic        [PIX_W-1:0]  pas1_q;

  for (genvar c = 0; c < NROW; c++) begin : g_mul
    logic signed [PROD_W-1:0] cx, px;
    assign cx = {{(PROD_W-COEF_W){coef_in[c*COEF_W+COEF_W-1]}}, coef_in[c*COEF_W +: COEF_W]};
    assign px = {{(PROD_W-PIX_W){1'b0}}, pix_in[(NROW-1-c)*PIX_W +: PIX_W]};
    assign prod_d[c] = cx * px;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NROW; c++) prod_q[c] <= '0;
      ofs_q  <= '0;
      byp1_q <= 1'b0;
      pas1_q <= '0;
    end else if (s1_en) begin
      for (int c = 0; c < NROW; c++) prod_q[c] <= prod_d[c];
      ofs_q  <= coef_in[(NCOL-1)*COEF_W +: COEF_W];
      byp1_q <= byp_in;
      pas1_q <= pix_in[(NROW-1-CH)*PIX_W +: PIX_W];
    end
  end

  // stage 2: accumulate offset and rounding constant
  logic signed [ACC_W-1:0] acc_d, acc_q, ofs_x;
  logic                    byp2_q;
  logic        [PIX_W-1:0] pas2_q;

  assign ofs_x = {{(ACC_W-COEF_W){ofs_q[COEF_W-1]}}, ofs_q} <<< FRAC_W;

  always_comb begin
    acc_d = ofs_x + RND;
    for (int c = 0; c < NROW; c++)
      acc_d = acc_d + {{(ACC_W-PROD_W){prod_q[c][PROD_W-1]}}, prod_q[c]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      byp2_q <= 1'b0;
      pas2_q <= '0;
    end else if (s2_en) begin
      acc_q  <= acc_d;
      byp2_q <= byp1_q;
      pas2_q <= pas1_q;
    end
  end

  // stage 3: scale down, clamp, pass-through select
  logic signed [ACC_W-1:0] shr;
  logic        [PIX_W-1:0] out_d, out_q;

  assign shr = acc_q >>> FRAC_W;

  always_comb begin
    if (byp2_q)                       out_d = pas2_q;
    else if (shr[ACC_W-1])            out_d = '0;
    else if (|shr[ACC_W-2:PIX_W])     out_d = '1;
    else                              out_d = shr[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_q <= '0;
    else if (s3_en) out_q <= out_d;
  end

  assign pix_out = out_q;
endmodule

// File: rtl/cmx_gamut_matrix.sv
module cmx_gamut_matrix
  import cmx_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [2*COEF_W-1:0]   cfg_wdata,
  input  logic                  frame_start,
  input  logic                  in_valid,
  input  logic [NROW*PIX_W-1:0] in_rgb,
  output logic                  out_valid,
  output logic [NROW*PIX_W-1:0] out_rgb,
  output logic [1:0]            cur_mode
);
  localparam int RW = NCOL * COEF_W;

  logic [NCOEF*COEF_W-1:0] sel_coef;
  logic                    byp;
  logic                    v1_q, v2_q, v3_q;

  cmx_mode_ctl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wmode   (cfg_wdata[1:0]),
    .frame_start (frame_start),
    .cur_mode    (cur_mode)
  );

  cmx_coef_bank #(.COEF_W(COEF_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cur_mode  (cur_mode),
    .sel_coef  (sel_coef)
  );

  assign byp = (cur_mode != MODE_SETA) && (cur_mode != MODE_SETB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= in_valid;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  for (genvar r = 0; r < NROW; r++) begin : g_row
    cmx_row #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .CH(r)) u_row (
      .clk     (clk),
      .rst_n   (rst_n),
      .s1_en   (in_valid),
      .s2_en   (v1_q),
      .s3_en   (v2_q),
      .byp_in  (byp),
      .pix_in  (in_rgb),
      .coef_in (sel_coef[r*RW +: RW]),
      .pix_out (out_rgb[(NROW-1-r)*PIX_W +: PIX_W])
    );
  end

  assign out_valid = v3_q;

  // R9: fixed three-cycle latency
  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);
  // R5: pass-through is bit-exact
  a_r5_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cur_mode == MODE_BYP) |-> ##3 (out_rgb == $past(in_rgb, 3)));
  // R11: idle output holds
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_rgb));
endmodule

// File: tb/cmx_gamut_matrix_tb.sv
module cmx_gamut_matrix_tb_top;
  localparam int PW = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        frame_start;
  logic        in_valid;
  logic [29:0] in_rgb;
  logic        out_valid;
  logic [29:0] out_rgb;
  logic [1:0]  cur_mode;

  always #2 clk = ~clk;

  cmx_gamut_matrix dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
    .in_rgb(in_rgb), .out_valid(out_valid), .out_rgb(out_rgb), .cur_mode(cur_mode)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit chk_on = 0;
  bit done   = 0;
  string tag = "R1";

  // reference model state
  logic [15:0] ma [12];
  logic [15:0] mb [12];
  logic [1:0]  m_pend, m_cur;
  int          due_q [$];
  logic [29:0] dat_q [$];
  logic [29:0] m_last;

  function automatic logic [29:0] calc(logic [29:0] rgb, logic [1:0] mode);
    logic [29:0] res;
    longint acc;
    if (mode != 2'd1 && mode != 2'd2) return rgb;
    res = '0;
    for (int r = 0; r < 3; r++) begin
      acc = 0;
      for (int c = 0; c < 3; c++)
        acc += longint'($signed(mode == 2'd1 ? ma[4*r+c] : mb[4*r+c])) *
               longint'(rgb[(2-c)*PW +: PW]);
      acc += longint'($signed(mode == 2'd1 ? ma[4*r+3] : mb[4*r+3])) * 8192;
      acc += 4096;
      acc = acc >>> 13;
      if (acc < 0) acc = 0;
      if (acc > 1023) acc = 1023;
      res[(2-r)*PW +: PW] = acc[9:0];
    end
    return res;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 12; i++) begin ma[i] = '0; mb[i] = '0; end
      m_pend = 0; m_cur = 0; m_last = '0;
      due_q.delete(); dat_q.delete();
    end else begin
      cyc++;
      if (in_valid) begin
        due_q.push_back(cyc + 2);
        dat_q.push_back(calc(in_rgb, m_cur));
      end
      if (frame_start) m_cur = m_pend;
      if (cfg_we) begin
        if (cfg_addr < 6) begin
          ma[2*cfg_addr] = cfg_wdata[15:0]; ma[2*cfg_addr+1] = cfg_wdata[31:16];
        end else if (cfg_addr >= 8 && cfg_addr < 14) begin
          mb[2*(cfg_addr-8)] = cfg_wdata[15:0]; mb[2*(cfg_addr-8)+1] = cfg_wdata[31:16];
        end else if (cfg_addr == 15) begin
          m_pend = (cfg_wdata[1:0] == 2'd3) ? 2'd0 : cfg_wdata[1:0];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      bit ev;
      ev = (due_q.size() > 0) && (due_q[0] == cyc);
      if (ev) begin
        void'(due_q.pop_front());
        m_last = dat_q.pop_front();
      end
      checks++;
      if (out_valid !== ev) begin
        fails++;
        $display("FAIL %s R9 out_valid act=%0b exp=%0b", tag, out_valid, ev);
      end
      checks++;
      if (out_rgb !== m_last) begin
        fails++;
        $display("FAIL %s out_rgb act=%h exp=%h", tag, out_rgb, m_last);
      end
      checks++;
      if (cur_mode !== m_cur) begin
        fails++;
        $display("FAIL %s R4 cur_mode act=%0d exp=%0d", tag, cur_mode, m_cur);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pix(input int r, input int g, input int b, input bit fs = 0);
    in_valid = 1; in_rgb = {r[9:0], g[9:0], b[9:0]}; frame_start = fs;
    @(negedge clk);
    in_valid = 0; frame_start = 0;
  endtask

  task automatic swap();
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    frame_start = 0; in_valid = 0; in_rgb = 0;
    idle(3);
    rst_n = 1;
    chk_on = 1;
    tag = "R1"; idle(2);

    tag = "R5"; pix(1, 2, 3); pix(1023, 0, 512); pix(77, 88, 99); idle(4);

    tag = "R2_R6";
    wr(0, 32'h2000_0000); wr(1, 32'h0000_0000); wr(2, 32'h0000_0000);
    wr(3, 32'h0000_2000); wr(4, 32'h0000_2000); wr(5, 32'h0000_0000);
    tag = "R5"; pix(10, 20, 30); idle(3);
    tag = "R2_R6"; wr(15, 1); swap(); pix(100, 200, 300); pix(5, 6, 7); idle(4);

    tag = "R10";
    wr(8, 32'h0000_1000); wr(9, 32'hFFFB_0000); wr(10, 32'h3FFF_3FFF);
    wr(11, 32'h0000_0000); wr(12, 32'h0000_E000); wr(13, 32'h000A_0000);
    pix(100, 200, 300); idle(4);
    wr(15, 2); pix(1, 2, 3); swap();
    tag = "R7"; pix(21, 600, 3); pix(23, 0, 0); idle(3);
    tag = "R8"; pix(100, 1023, 0); pix(0, 0, 0); pix(1023, 1023, 1023); idle(4);

    tag = "R4"; wr(15, 1); pix(21, 600, 3, 1); pix(21, 600, 3); idle(4);
    tag = "R5"; wr(15, 0); swap(); pix(21, 600, 3); idle(4);

    tag = "R3"; wr(15, 3); swap(); pix(50, 60, 70); idle(4);

    tag = "R12"; wr(6, 32'h1234_5678); wr(7, 32'hFFFF_FFFF); wr(14, 32'h0000_0002);
    wr(15, 1); swap(); pix(100, 200, 300); idle(3); swap(); idle(1);
    pix(100, 200, 300); idle(4);

    tag = "R9_R11";
    pix(1, 2, 3); pix(4, 5, 6); pix(7, 8, 9); idle(2); pix(11, 12, 13);
    idle(1); pix(14, 15, 16); idle(6);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule